// File: doc/BRIEF.md
# Power Mode and Clock Divider Controller

This block decides how fast the bus masters of a small CPU subsystem run and which low-power state the subsystem is in. Software writes a 3-bit clock-select value; the block divides the base clock for every bus master by 2, 4, 8, 16 or 32. On-chip peripherals keep the undivided clock. A new divider value does not take effect at the write. It waits until the bus interface reports the end of the current bus cycle, so a transfer never changes speed halfway through. Because a bus access always takes the same number of master-clock states, it stretches in base-clock periods by the divide ratio: at divide-by-4 a two-state I/O access takes 8 base periods.

A sleep strobe from the CPU, qualified by three configuration bits, moves the block into sleep or software standby. Any interrupt ends sleep. Only an external interrupt ends software standby. Both exits resume at the divider that was in force before, so medium speed comes back as medium speed. A low reset pin, a watchdog overflow pulse or a low hardware-standby pin forces the block out of whatever it is doing. A reset returns the divider to full speed. The block drives two single-cycle clock enables, one for masters and one for peripherals, and a mode code. The enables come from a free-running prescaler.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While rst_pin_n is low, mode_o is 0 (reset) and both enables are low. One clock after it goes high, mode_o is 1 (full speed) and mst_ce is high on every cycle.
- R2: A write of a nonzero select value at full speed leaves mode_o at 1 and mst_ce high on every cycle until a bus_end strobe arrives in a later cycle than the write.
- R3: After that strobe, mode_o is 2 (medium speed) and mst_ce is high in exactly one of every 2^s cycles for select value s of 1 to 5, while per_ce stays high on every cycle.
- R4: Select values 6 and 7 give the same divide-by-32 as value 5.
- R5: Writing select value 0 in medium speed keeps the divided rate until a later bus_end strobe, after which mode_o is 1.
- R6: sleep_req with stby_sel=0 and lowspd_on=0 gives mode_o 3 (sleep), with mst_ce low and per_ce high. int_req or ext_int then returns to the previous speed mode.
- R7: sleep_req with stby_sel=1, lowspd_on=0 and wdt_pss=0 gives mode_o 4 (software standby), with both enables low. int_req alone does not exit this mode; ext_int returns to the previous speed mode.
- R8: sleep_req is ignored while lowspd_on=1, or while stby_sel=1 and wdt_pss=1. In either case the block keeps running in its current speed mode.
- R9: A wdt_ovf pulse in any mode gives mode_o 0 one cycle later, with both enables low. The next cycle is full speed, because the select value has been cleared.
- R10: hstby_n low gives mode_o 5 (hardware standby) from any mode, with both enables low. It takes precedence over wdt_ovf, and select writes are ignored while it is low. When hstby_n rises, the block spends one cycle in reset and then runs at full speed.
- R11: The prescaler counts from 0, starting at reset release, and is not cleared by a divider change, a watchdog reset or any standby. After n clock edges since reset release, a divided mst_ce pulse occurs exactly when the low s bits of n are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| hstby_n | input | 1 | Hardware standby pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| sel_we | input | 1 | Write strobe for the clock-select register |
| sel_wdata | input | SEL_W | Clock-select value to write |
| bus_end | input | 1 | End of the current bus cycle |
| sleep_req | input | 1 | Sleep instruction executed |
| stby_sel | input | 1 | Standby select configuration bit |
| lowspd_on | input | 1 | Low-speed-on configuration bit |
| wdt_pss | input | 1 | Watchdog prescaler-select configuration bit |
| int_req | input | 1 | Internal interrupt request |
| ext_int | input | 1 | External interrupt request |
| mst_ce | output | 1 | Clock enable for the CPU and the other bus masters |
| per_ce | output | 1 | Clock enable for the peripherals |
| mode_o | output | 3 | Mode code: 0 reset, 1 full, 2 medium, 3 sleep, 4 software standby, 5 hardware standby |

## Verification
The assertions check the following on every cycle:
- mst_ce is held low outside the two running modes, and both enables are low in either standby.
- Full speed changes to medium speed only after a bus_end strobe.
- Software standby holds unless an external interrupt, watchdog or standby pin acts.
- The watchdog and the standby pin force their modes on the next edge.
- Divided enable pulses are never back to back.

Only the bench scenarios can show the exact position of each pulse relative to the free-running prescaler for every select value, including the clamped ones. The same holds for the speed mode that is restored after each kind of wake-up and for the clearing of the divider by reset and by hardware standby.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;

   // Externally visible mode code carried on mode_o
   typedef enum logic [2:0] {
      MD_RESET  = 3'd0,
      MD_FULL   = 3'd1,
      MD_SLOW   = 3'd2,
      MD_SLEEP  = 3'd3,
      MD_SWSTBY = 3'd4,
      MD_HWSTBY = 3'd5
   } pwr_mode_e;

   // Internal controller state; speed is derived from the applied divider
   typedef enum logic [2:0] {
      ST_RESET  = 3'd0,
      ST_RUN    = 3'd1,
      ST_SLEEP  = 3'd2,
      ST_SWSTBY = 3'd3,
      ST_HWSTBY = 3'd4
   } pwr_state_e;

endpackage

// File: rtl/pwr_prescaler.sv
module pwr_prescaler #(
   parameter int SHIFT_MAX = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [SHIFT_MAX:0]   tick
);

   localparam int CNT_W = SHIFT_MAX;

   logic [CNT_W-1:0] cnt_q;

   // Free-running: only the reset pin clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign tick[0] = 1'b1;

   // One tap per divide ratio: active when the low k bits are all ones
   for (genvar k = 1; k <= SHIFT_MAX; k++) begin : g_tap
      assign tick[k] = &cnt_q[k-1:0];
   end

endmodule

// File: rtl/pwr_div_sel.sv
module pwr_div_sel #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_data,
   input  logic             bus_end,
   output logic [SEL_W-1:0] div_q
);

   logic [SEL_W-1:0] sel_q;

   // The written value waits in sel_q until a bus cycle ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         div_q <= '0;
      end else if (clr) begin
         sel_q <= '0;
         div_q <= '0;
      end else if (run) begin
         if (wr_en)   sel_q <= wr_data;
         if (bus_end) div_q <= sel_q;
      end
   end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_clk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hstby_n,
   input  logic       wdt_ovf,
   input  logic       sleep_req,
   input  logic       stby_sel,
   input  logic       lowspd_on,
   input  logic       wdt_pss,
   input  logic       int_req,
   input  logic       ext_int,
   output pwr_state_e state_q
);

   pwr_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (!hstby_n) begin
         state_d = ST_HWSTBY;
      end else if (state_q == ST_HWSTBY || wdt_ovf) begin
         state_d = ST_RESET;
      end else begin
         unique case (state_q)
            ST_RESET:  state_d = ST_RUN;
            ST_RUN: begin
               if (sleep_req && !lowspd_on) begin
                  if (!stby_sel)     state_d = ST_SLEEP;
                  else if (!wdt_pss) state_d = ST_SWSTBY;
               end
            end
            ST_SLEEP:  if (int_req || ext_int) state_d = ST_RUN;
            ST_SWSTBY: if (ext_int)            state_d = ST_RUN;
            default:   state_d = ST_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RESET;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
   import pwr_clk_pkg::*;
#(
   parameter int SEL_W     = 3,
   parameter int SHIFT_MAX = 5
) (
   input  logic             clk,
   input  logic             rst_pin_n,
   input  logic             hstby_n,
   input  logic             wdt_ovf,
   input  logic             sel_we,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             bus_end,
   input  logic             sleep_req,
   input  logic             stby_sel,
   input  logic             lowspd_on,
   input  logic             wdt_pss,
   input  logic             int_req,
   input  logic             ext_int,
   output logic             mst_ce,
   output logic             per_ce,
   output logic [2:0]       mode_o
);

   localparam int IDX_W = $clog2(SHIFT_MAX + 1);

   if (SEL_W < 1) begin : g_bad_sel
      $error("pwr_clk_ctrl: SEL_W must be at least 1");
   end
   if (SHIFT_MAX < 1) begin : g_bad_shift
      $error("pwr_clk_ctrl: SHIFT_MAX must be at least 1");
   end
   if ((1 << SEL_W) - 1 < SHIFT_MAX) begin : g_bad_range
      $error("pwr_clk_ctrl: select field too narrow for SHIFT_MAX");
   end

   pwr_state_e           state_q;
   logic [SEL_W-1:0]     div_q;
   logic [SHIFT_MAX:0]   tick;
   logic [IDX_W-1:0]     shift_idx;
   logic                 run;
   logic                 clr;

   assign run = (state_q == ST_RUN);
   assign clr = (state_q == ST_RESET) || (state_q == ST_HWSTBY);

   pwr_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_pin_n),
      .hstby_n   (hstby_n),
      .wdt_ovf   (wdt_ovf),
      .sleep_req (sleep_req),
      .stby_sel  (stby_sel),
      .lowspd_on (lowspd_on),
      .wdt_pss   (wdt_pss),
      .int_req   (int_req),
      .ext_int   (ext_int),
      .state_q   (state_q)
   );

   pwr_div_sel #(.SEL_W(SEL_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_pin_n),
      .clr     (clr),
      .run     (run),
      .wr_en   (sel_we),
      .wr_data (sel_wdata),
      .bus_end (bus_end),
      .div_q   (div_q)
   );

   pwr_prescaler #(.SHIFT_MAX(SHIFT_MAX)) u_pre (
      .clk   (clk),
      .rst_n (rst_pin_n),
      .tick  (tick)
   );

   // Select codes beyond the deepest ratio saturate at it
   always_comb begin
      if (32'(div_q) > SHIFT_MAX) shift_idx = IDX_W'(SHIFT_MAX);
      else                        shift_idx = IDX_W'(div_q);
   end

   assign mst_ce = run && tick[shift_idx];
   assign per_ce = run || (state_q == ST_SLEEP);

   always_comb begin
      unique case (state_q)
         ST_RUN:    mode_o = (div_q == '0) ? MD_FULL : MD_SLOW;
         ST_SLEEP:  mode_o = MD_SLEEP;
         ST_SWSTBY: mode_o = MD_SWSTBY;
         ST_HWSTBY: mode_o = MD_HWSTBY;
         default:   mode_o = MD_RESET;
      endcase
   end

endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk (
   input logic       clk,
   input logic       rst_pin_n,
   input logic       hstby_n,
   input logic       wdt_ovf,
   input logic       bus_end,
   input logic       ext_int,
   input logic       mst_ce,
   input logic       per_ce,
   input logic [2:0] mode_o
);

   // R6 R7 R9 R10: master enable only while running
   assert_mst_gated_R6: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (mode_o != 3'd1 && mode_o != 3'd2) |-> !mst_ce);

   // R7 R10: standby stops the peripheral enable too
   assert_per_stopped_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (mode_o == 3'd4 || mode_o == 3'd5) |-> !per_ce);

   // R1: full speed means an enable every cycle
   assert_full_rate_R1: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (mode_o == 3'd1) |-> mst_ce);

   // R2: speed change only after a bus cycle end
   assert_slow_after_bus_end_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
      ($past(mode_o) == 3'd1 && mode_o == 3'd2) |-> $past(bus_end));

   // R3: divided pulses are single-cycle
   assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (mode_o == 3'd2 && $past(mode_o) == 3'd2 && $past(mst_ce)) |-> !mst_ce);

   // R7: software standby holds without an external interrupt
   assert_swstby_holds_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (mode_o == 3'd4 && !ext_int && hstby_n && !wdt_ovf) |=> (mode_o == 3'd4));

   // R9: watchdog overflow forces reset
   assert_wdt_reset_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (wdt_ovf && hstby_n) |=> (mode_o == 3'd0));

   // R10: standby pin forces hardware standby
   assert_hw_standby_R10: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (!hstby_n) |=> (mode_o == 3'd5));

endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk u_chk (.*);

// File: tb/pwr_clk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_pin_n = 1'b0;
   logic       hstby_n = 1'b1;
   logic       wdt_ovf = 1'b0;
   logic       sel_we = 1'b0;
   logic [2:0] sel_wdata = '0;
   logic       bus_end = 1'b0;
   logic       sleep_req = 1'b0;
   logic       stby_sel = 1'b0;
   logic       lowspd_on = 1'b0;
   logic       wdt_pss = 1'b0;
   logic       int_req = 1'b0;
   logic       ext_int = 1'b0;
   logic       mst_ce;
   logic       per_ce;
   logic [2:0] mode_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwr_clk_ctrl uut (
      .clk(clk), .rst_pin_n(rst_pin_n), .hstby_n(hstby_n), .wdt_ovf(wdt_ovf),
      .sel_we(sel_we), .sel_wdata(sel_wdata), .bus_end(bus_end),
      .sleep_req(sleep_req), .stby_sel(stby_sel), .lowspd_on(lowspd_on),
      .wdt_pss(wdt_pss), .int_req(int_req), .ext_int(ext_int),
      .mst_ce(mst_ce), .per_ce(per_ce), .mode_o(mode_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // one clock edge; inputs are set at a negedge, outputs read at the next
   task automatic step();
      @(posedge clk);
      if (rst_pin_n) cyc++;
      @(negedge clk);
   endtask

   task automatic write_sel(input int v);
      sel_wdata = 3'(v);
      sel_we = 1'b1;
      step();
      sel_we = 1'b0;
   endtask

   task automatic end_bus();
      bus_end = 1'b1;
      step();
      bus_end = 1'b0;
   endtask

   task automatic pulse_sleep();
      sleep_req = 1'b1;
      step();
      sleep_req = 1'b0;
   endtask

   function automatic int expect_ce(input int s);
      int eff = (s > 5) ? 5 : s;
      int mask = (1 << eff) - 1;
      return ((cyc & mask) == mask) ? 1 : 0;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      @(negedge clk);
      repeat (3) step();
      check("R1 mode in reset", mode_o, 0);
      check("R1 mst_ce in reset", mst_ce, 0);
      check("R1 per_ce in reset", per_ce, 0);
      rst_pin_n = 1'b1;
      cyc = 0;
      step();
      check("R1 mode after release", mode_o, 1);
      check("R1 mst_ce after release", mst_ce, 1);

      // sweep every select value, including the clamped ones
      for (int s = 1; s <= 7; s++) begin
         write_sel(s);
         for (int i = 0; i < 3; i++) begin
            check("R2 mode before bus end", mode_o, 1);
            check("R2 mst_ce before bus end", mst_ce, 1);
            step();
         end
         end_bus();
         for (int i = 0; i < 64; i++) begin
            check((s > 5) ? "R4 clamped pulse" : "R3 R11 divided pulse", mst_ce, expect_ce(s));
            check("R3 per_ce full rate", per_ce, 1);
            check("R3 mode medium", mode_o, 2);
            step();
         end
         write_sel(0);
         step();
         check("R5 mode held until bus end", mode_o, 2);
         check("R5 rate held until bus end", mst_ce, expect_ce(s));
         end_bus();
         check("R5 mode back to full", mode_o, 1);
         check("R5 mst_ce back to full", mst_ce, 1);
      end

      // sleep and wake, medium speed at divide-by-4
      write_sel(2);
      end_bus();
      pulse_sleep();
      for (int i = 0; i < 4; i++) begin
         check("R6 sleep mode", mode_o, 3);
         check("R6 sleep mst_ce", mst_ce, 0);
         check("R6 sleep per_ce", per_ce, 1);
         step();
      end
      int_req = 1'b1; step(); int_req = 1'b0;
      check("R6 wake by internal irq", mode_o, 2);
      check("R6 rate after wake", mst_ce, expect_ce(2));
      pulse_sleep();
      ext_int = 1'b1; step(); ext_int = 1'b0;
      check("R6 wake by external irq", mode_o, 2);

      // software standby
      stby_sel = 1'b1;
      pulse_sleep();
      check("R7 swstby mode", mode_o, 4);
      check("R7 swstby mst_ce", mst_ce, 0);
      check("R7 swstby per_ce", per_ce, 0);
      int_req = 1'b1; step(); step(); int_req = 1'b0;
      check("R7 internal irq ignored", mode_o, 4);
      ext_int = 1'b1; step(); ext_int = 1'b0;
      check("R7 wake by external irq", mode_o, 2);
      for (int i = 0; i < 8; i++) begin
         check("R7 R11 rate after standby", mst_ce, expect_ce(2));
         step();
      end

      // ignored sleep requests
      wdt_pss = 1'b1;
      pulse_sleep();
      check("R8 pss set ignores sleep", mode_o, 2);
      wdt_pss = 1'b0; stby_sel = 1'b0; lowspd_on = 1'b1;
      pulse_sleep();
      check("R8 lowspd ignores sleep", mode_o, 2);
      stby_sel = 1'b1;
      pulse_sleep();
      check("R8 lowspd ignores standby", mode_o, 2);
      lowspd_on = 1'b0; stby_sel = 1'b0;

      // watchdog from medium speed and from software standby
      wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
      check("R9 wdt reset mode", mode_o, 0);
      check("R9 wdt reset mst_ce", mst_ce, 0);
      check("R9 wdt reset per_ce", per_ce, 0);
      step();
      check("R9 full after wdt", mode_o, 1);
      check("R9 mst_ce after wdt", mst_ce, 1);
      write_sel(3);
      end_bus();
      stby_sel = 1'b1;
      pulse_sleep();
      stby_sel = 1'b0;
      check("R9 setup swstby", mode_o, 4);
      wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
      check("R9 wdt from swstby", mode_o, 0);
      step();
      check("R9 select cleared", mode_o, 1);
      for (int i = 0; i < 8; i++) begin
         check("R11 prescaler not cleared by wdt", mst_ce, 1);
         step();
      end

      // hardware standby
      write_sel(4);
      end_bus();
      check("R10 setup medium", mode_o, 2);
      hstby_n = 1'b0; wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
      check("R10 hw standby over wdt", mode_o, 5);
      check("R10 hw standby mst_ce", mst_ce, 0);
      check("R10 hw standby per_ce", per_ce, 0);
      write_sel(5);
      check("R10 held in hw standby", mode_o, 5);
      hstby_n = 1'b1; step();
      check("R10 reset after hw standby", mode_o, 0);
      step();
      check("R10 full after hw standby", mode_o, 1);
      end_bus();
      for (int i = 0; i < 4; i++) begin
         check("R10 write ignored in standby", mode_o, 1);
         check("R10 mst_ce after standby", mst_ce, 1);
         step();
      end

      // a prescaler phase check at divide-by-32 after all the above
      write_sel(5);
      end_bus();
      for (int i = 0; i < 40; i++) begin
         check("R11 phase since release", mst_ce, expect_ce(5));
         step();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule